// File: doc/BRIEF.md
# Calibrated Real-Time Seconds Counter

This block keeps wall-clock time as a 32-bit count of seconds. It runs from a clock at the reference rate, nominally 32768 Hz. A two-stage prescaler divides that clock first by `DIV_LO` (256) to a 1/128 s step, then by `DIV_HI` (128) to a 1 Hz second event. Each second event pulses `sec_tick` for one cycle and advances `sec_count`. The `run_en` input gates all counting.

A single 32-bit adjust register, written through `wr_en`/`wr_data` and read back on `rd_data`, corrects oscillator drift on two scales.

- Coarse calibration adds or drops one whole second once every match+1 seconds. The match value sits in bits [18:0], the adjust mode in bits [20:19] and the calibration enable in bit 23.
- Fine trim is a one-shot request that lengthens or shortens a single second by one first-stage period. Bit 24 selects insert (1) or remove (0), and bit 25 marks the request valid.

Two small state machines hold the control state:

- The calibration machine has the states CAL_IDLE and CAL_COUNT. Any register write moves it to CAL_COUNT when the enable bit and mode bit 20 are both set, and to CAL_IDLE otherwise. In CAL_COUNT it counts seconds and applies the correction on the matching one.
- The fine-trim machine has the states FINE_IDLE and FINE_ARMED. A write with bit 25 set arms it, and a write with bit 25 clear disarms it. In FINE_ARMED the next first-stage wrap consumes the request and returns the machine to FINE_IDLE.

Top module: `rtc_cal_core`

## Requirements
- R1: After reset `sec_count` is 0, `sec_tick` is 0 and `rd_data` reads 0.
- R2: While `run_en` is high and no trim is active, `sec_tick` pulses for exactly one cycle every `DIV_LO*DIV_HI` cycles, and `sec_count` rises by 1 in that same cycle and changes at no other time.
- R3: While `run_en` is low, the prescaler and `sec_count` hold and no tick occurs. After `run_en` returns high, counting resumes where it stopped, so the interrupted second is longer by exactly the number of paused cycles.
- R4: Register bits 0-20 and 23-25 are stored. `rd_data` reads the written value ANDed with 0x039FFFFF, with bit 25 showing whether a fine request is still pending; every other bit reads 0.
- R5: With bit 23 set and mode 3 (bits [20:19] = 2'b11), every (match+1)-th second event advances `sec_count` by 2 instead of 1.
- R6: With bit 23 set and mode 2 (2'b10), every (match+1)-th second event leaves `sec_count` unchanged, while `sec_tick` still pulses.
- R7: Modes 0 and 1, or any mode with bit 23 clear, apply no correction: every second event adds exactly 1.
- R8: Every register write with bit 23 set restarts the interval count of seconds from zero.
- R9: A fine request with bit 24 = 1 makes the second containing the next first-stage wrap longer by `DIV_LO` cycles.
- R10: A fine request with bit 24 = 0 makes the second containing the next first-stage wrap shorter by `DIV_LO` cycles.
- R11: The pending bit 25 clears itself once the request is consumed at a first-stage wrap. It stays set while `run_en` is low, and a write with bit 25 = 0 cancels a pending request. Bit 24 keeps its written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Enables prescaler and seconds counting |
| wr_en | input | 1 | Writes `wr_data` into the adjust register |
| wr_data | input | 32 | Adjust register write value |
| rd_data | output | 32 | Adjust register read-back, including the live pending bit |
| sec_count | output | 32 | Seconds count |
| sec_tick | output | 1 | One-cycle pulse at each second event |

## Verification
The bench runs the counter with no trim first, then enables each coarse mode over several intervals, so that ticks adding 2 or 0 show up at the matching position and nowhere else. It rewrites an unchanged calibration value partway through an interval; this separates a design that restarts the interval count from one that keeps counting. Fine inserts and removes are issued just after a tick, and the spacing between ticks tells them apart: 40 cycles for an insert and 24 for a remove, against a nominal 32. A pause in `run_en` confirms that time is held rather than lost, and mask read-back with the counter stopped shows the pending bit is kept until a wrap consumes it.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
    localparam int REG_W        = 32;
    localparam int MATCH_W      = 19;
    localparam int MODE_LSB     = 19;
    localparam int CAL_EN_BIT   = 23;
    localparam int FINE_DIR_BIT = 24;
    localparam int FINE_VLD_BIT = 25;
    localparam logic [REG_W-1:0] WR_MASK = 32'h039F_FFFF;

    typedef enum logic [1:0] {
        ADJ_OFF0    = 2'd0,
        ADJ_OFF1    = 2'd1,
        ADJ_SWALLOW = 2'd2,
        ADJ_INSERT  = 2'd3
    } adj_mode_e;

    typedef enum logic {
        CAL_IDLE  = 1'b0,
        CAL_COUNT = 1'b1
    } cal_state_e;

    typedef enum logic {
        FINE_IDLE  = 1'b0,
        FINE_ARMED = 1'b1
    } fine_state_e;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV_LO = 256,
    parameter int DIV_HI = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic fine_req,
    input  logic fine_ins,
    output logic lo_wrap,
    output logic sec_wrap
);
    localparam int LO_W = (DIV_LO > 1) ? $clog2(DIV_LO) : 1;
    localparam int HI_W = $clog2(DIV_HI) + 1;
    localparam logic [LO_W-1:0] LO_LAST = LO_W'(DIV_LO - 1);
    localparam logic [HI_W-1:0] HI_MOD  = HI_W'(DIV_HI);

    logic [LO_W-1:0] lo_cnt, lo_nxt;
    logic [HI_W-1:0] hi_cnt, hi_sum, hi_nxt;
    logic [1:0]      hi_step;

    // Power-of-two first stage rolls over naturally; other ratios compare.
    generate
        if ((1 << LO_W) == DIV_LO) begin : g_lo_pow2
            assign lo_nxt = lo_cnt + 1'b1;
        end else begin : g_lo_mod
            assign lo_nxt = (lo_cnt == LO_LAST) ? '0 : lo_cnt + 1'b1;
        end
    endgenerate

    assign lo_wrap = run_en && (lo_cnt == LO_LAST);

    // A pending fine request changes how far the second stage moves at a wrap.
    always_comb begin
        if (fine_req && fine_ins)
            hi_step = 2'd0;
        else if (fine_req)
            hi_step = 2'd2;
        else
            hi_step = 2'd1;
    end

    assign hi_sum   = hi_cnt + HI_W'(hi_step);
    assign sec_wrap = lo_wrap && (hi_sum >= HI_MOD);
    assign hi_nxt   = (hi_sum >= HI_MOD) ? hi_sum - HI_MOD : hi_sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
        end else if (run_en) begin
            lo_cnt <= lo_nxt;
            if (lo_wrap)
                hi_cnt <= hi_nxt;
        end
    end
endmodule

// File: rtl/rtc_fine_fsm.sv
module rtc_fine_fsm
    import rtc_cal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_valid,
    input  logic lo_wrap,
    output logic fine_pend
);
    fine_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= FINE_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FINE_IDLE: begin
                if (wr_en && wr_valid)
                    state_d = FINE_ARMED;
            end
            FINE_ARMED: begin
                if (wr_en)
                    state_d = wr_valid ? FINE_ARMED : FINE_IDLE;
                else if (lo_wrap)
                    state_d = FINE_IDLE;
            end
            default: state_d = FINE_IDLE;
        endcase
    end

    always_comb begin
        fine_pend = (state_q == FINE_ARMED);
    end
endmodule

// File: rtl/rtc_cal_fsm.sv
module rtc_cal_fsm
    import rtc_cal_pkg::*;
#(
    parameter int M_W = MATCH_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           wr_arm,
    input  logic           sec_wrap,
    input  logic [M_W-1:0] match,
    input  adj_mode_e      mode,
    output logic [1:0]     sec_step
);
    cal_state_e     state_q, state_d;
    logic [M_W-1:0] interval_q;
    logic           hit;

    assign hit = (state_q == CAL_COUNT) && (interval_q == match);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= CAL_IDLE;
            interval_q <= '0;
        end else begin
            state_q <= state_d;
            if (wr_en)
                interval_q <= '0;
            else if (sec_wrap && state_q == CAL_COUNT)
                interval_q <= hit ? '0 : interval_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAL_IDLE:  if (wr_en && wr_arm)  state_d = CAL_COUNT;
            CAL_COUNT: if (wr_en && !wr_arm) state_d = CAL_IDLE;
            default:   state_d = CAL_IDLE;
        endcase
    end

    always_comb begin
        sec_step = 2'd1;
        if (hit) begin
            unique case (mode)
                ADJ_INSERT:  sec_step = 2'd2;
                ADJ_SWALLOW: sec_step = 2'd0;
                default:     sec_step = 2'd1;
            endcase
        end
    end
endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
    import rtc_cal_pkg::*;
#(
    parameter int DIV_LO = 256,
    parameter int DIV_HI = 128,
    parameter int CNT_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic [CNT_W-1:0] sec_count,
    output logic             sec_tick
);
    localparam logic [REG_W-1:0] VLD_ONLY = REG_W'(1) << FINE_VLD_BIT;

    logic [REG_W-1:0] adj_q;
    logic             fine_pend;
    logic             lo_wrap;
    logic             sec_wrap;
    logic [1:0]       sec_step;
    logic             wr_arm;
    adj_mode_e        cur_mode;

    assign cur_mode = adj_mode_e'(adj_q[MODE_LSB +: 2]);
    assign wr_arm   = wr_data[CAL_EN_BIT] && wr_data[MODE_LSB + 1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            adj_q <= '0;
        else if (wr_en)
            adj_q <= wr_data & WR_MASK;
    end

    assign rd_data = (adj_q & ~VLD_ONLY) | (fine_pend ? VLD_ONLY : '0);

    rtc_prescaler #(
        .DIV_LO (DIV_LO),
        .DIV_HI (DIV_HI)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .fine_req (fine_pend),
        .fine_ins (adj_q[FINE_DIR_BIT]),
        .lo_wrap  (lo_wrap),
        .sec_wrap (sec_wrap)
    );

    rtc_fine_fsm u_fine (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_valid  (wr_data[FINE_VLD_BIT]),
        .lo_wrap   (lo_wrap),
        .fine_pend (fine_pend)
    );

    rtc_cal_fsm #(
        .M_W (MATCH_W)
    ) u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_arm   (wr_arm),
        .sec_wrap (sec_wrap),
        .match    (adj_q[MATCH_W-1:0]),
        .mode     (cur_mode),
        .sec_step (sec_step)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_count <= '0;
            sec_tick  <= 1'b0;
        end else begin
            sec_tick <= sec_wrap;
            if (sec_wrap)
                sec_count <= sec_count + CNT_W'(sec_step);
        end
    end
endmodule

// File: rtl/rtc_cal_core_chk.sv
module rtc_cal_core_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             wr_en,
    input logic             sec_tick,
    input logic [CNT_W-1:0] sec_count,
    input logic             cal_on,
    input logic             cal_mode_hi,
    input logic             fine_vld_rd,
    input logic             fine_pend,
    input logic             lo_wrap
);
    p_quiet_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |-> $stable(sec_count));

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

    p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !sec_tick);

    p_step_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> (sec_count - $past(sec_count)) <= CNT_W'(2));

    p_plain_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !($past(cal_on) && $past(cal_mode_hi)))
        |-> sec_count == $past(sec_count) + CNT_W'(1));

    p_fine_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_pend && lo_wrap && !wr_en) |=> !fine_vld_rd);
endmodule

bind rtc_cal_core rtc_cal_core_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .wr_en       (wr_en),
    .sec_tick    (sec_tick),
    .sec_count   (sec_count),
    .cal_on      (rd_data[23]),
    .cal_mode_hi (rd_data[20]),
    .fine_vld_rd (rd_data[25]),
    .fine_pend   (fine_pend),
    .lo_wrap     (lo_wrap)
);

// File: tb/rtc_cal_core_tb_top.sv
module rtc_cal_core_tb_top;
    localparam int DLO = 8;
    localparam int DHI = 4;
    localparam int PER = DLO * DHI;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] sec_count;
    logic        sec_tick;

    always #2 clk = ~clk;

    rtc_cal_core #(.DIV_LO(DLO), .DIV_HI(DHI), .CNT_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data),
        .sec_count(sec_count), .sec_tick(sec_tick)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int last_tick = 0;
    int          q_gap[$];
    logic [31:0] q_cnt[$];
    string       q_tag[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic push(input int gap, input logic [31:0] cnt, input string tag);
        q_gap.push_back(gap);
        q_cnt.push_back(cnt);
        q_tag.push_back(tag);
    endtask

    task automatic drain();
        wait (q_cnt.size() == 0);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    // Monitor: pops the expected tick and compares spacing and count.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && sec_tick) begin
            if (q_cnt.size() == 0) begin
                chk("R2/R3 unexpected tick", 32'd1, 32'd0);
            end else begin
                automatic int          g = q_gap.pop_front();
                automatic logic [31:0] c = q_cnt.pop_front();
                automatic string       t = q_tag.pop_front();
                if (g != 0)
                    chk({t, " gap"}, 32'(cyc - last_tick), 32'(g));
                chk({t, " count"}, sec_count, c);
            end
            last_tick = cyc;
        end
        if (cyc > 20000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", sec_count, 32'd0);
        chk("R1 tick", {31'd0, sec_tick}, 32'd0);
        chk("R1 rd_data", rd_data, 32'd0);

        // R4 mask read-back and R11 hold while stopped
        reg_write(32'hFFFF_FFFF);
        chk("R4 mask", rd_data, 32'h039F_FFFF);
        repeat (20) @(negedge clk);
        chk("R11 pending held while stopped", rd_data, 32'h039F_FFFF);
        chk("R3 count held while stopped", sec_count, 32'd0);
        reg_write(32'h0);
        chk("R11 cancel by write", rd_data, 32'd0);

        // R2 plain counting
        push(0, 32'd1, "R2");
        push(PER, 32'd2, "R2");
        push(PER, 32'd3, "R2");
        @(negedge clk);
        run_en = 1'b1;
        drain();

        // R5 insert mode, match 2
        reg_write(32'h0098_0002);
        chk("R4 cal readback", rd_data, 32'h0098_0002);
        push(PER, 32'd4, "R5");  push(PER, 32'd5, "R5");
        push(PER, 32'd7, "R5");  push(PER, 32'd8, "R5");
        push(PER, 32'd9, "R5");  push(PER, 32'd11, "R5");
        push(PER, 32'd12, "R5"); push(PER, 32'd13, "R5");
        drain();
        // R8 rewrite restarts the interval
        reg_write(32'h0098_0002);
        push(PER, 32'd14, "R8"); push(PER, 32'd15, "R8");
        push(PER, 32'd17, "R8");
        drain();

        // R6 swallow mode, match 1
        reg_write(32'h0090_0001);
        push(PER, 32'd18, "R6"); push(PER, 32'd18, "R6");
        push(PER, 32'd19, "R6"); push(PER, 32'd19, "R6");
        drain();

        // R7 no correction cases
        reg_write(32'h0088_0000);
        push(PER, 32'd20, "R7 mode1"); push(PER, 32'd21, "R7 mode1");
        push(PER, 32'd22, "R7 mode1");
        drain();
        reg_write(32'h0018_0000);
        push(PER, 32'd23, "R7 disabled"); push(PER, 32'd24, "R7 disabled");
        push(PER, 32'd25, "R7 disabled");
        drain();
        reg_write(32'h0080_0000);
        push(PER, 32'd26, "R7 mode0"); push(PER, 32'd27, "R7 mode0");
        drain();

        // R9 fine insert
        reg_write(32'h0300_0000);
        chk("R11 pending after write", rd_data, 32'h0300_0000);
        push(PER + DLO, 32'd28, "R9"); push(PER, 32'd29, "R9");
        drain();
        chk("R11 self clear after insert", rd_data, 32'h0100_0000);

        // R10 fine remove
        reg_write(32'h0200_0000);
        push(PER - DLO, 32'd30, "R10"); push(PER, 32'd31, "R10");
        drain();
        chk("R11 self clear after remove", rd_data, 32'd0);

        // R3 pause
        @(negedge clk);
        run_en = 1'b0;
        repeat (25) @(negedge clk);
        chk("R3 count mid pause", sec_count, 32'd31);
        repeat (25) @(negedge clk);
        chk("R3 count end pause", sec_count, 32'd31);
        push(PER + 50, 32'd32, "R3"); push(PER, 32'd33, "R3");
        run_en = 1'b1;
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule